// File: doc/BRIEF.md
# Read-Set Interference Tracker

This block follows the cache lines that a transaction has loaded. It counts the events that may have made that read set stale. Each cache line index has a tag entry holding a live bit, a transaction stamp and the id of the owning hardware thread. Every thread has a user-writable 8-bit sequence register and a 64-bit interference counter that software can read but not write.

Every load writes the loading thread's current sequence value and its thread id into the line's entry. A line can leave the cache in two ways: a remote store invalidates it, or a local capacity or conflict miss evicts it. In either case the entry is compared with the owning thread's live sequence value. On a match, that thread's counter goes up by one and a cause code records why. A taken trap or exception bumps the trapping thread's counter unconditionally. When the interrupt mode is on, each increment also raises a one-cycle request pulse.

Software reads a thread's counter when a transaction starts and again at commit. A changed value means the read set may be inconsistent, so the transaction is aborted. Load, displacement, trap and register-write inputs are single-cycle strobes. The block takes one of each per cycle and never applies back-pressure, so these inputs have no ready signal.

Top module: `rs_track_top`

## Requirements
- R1: After reset every sequence register, counter and cause code reads zero and no line is live. A displacement of a line that has not been loaded since reset changes no counter.
- R2: A sequence write stores the 8-bit value into the selected thread's register, and the new value is readable on the following cycle.
- R3: A load stamps the line with the loading thread's sequence value as it stood before any register write in that same cycle, and records the loading thread as the line's owner.
- R4: A displacement with `dsp_remote`=1 of a live line whose stamp equals the owner's sequence register raises the owner's counter by one and sets its cause to 2 (remote update).
- R5: A displacement with `dsp_remote`=0 under the same match condition raises the owner's counter by one and sets its cause to 1 (local capacity/conflict eviction).
- R6: A displacement of a line whose stamp differs from the owner's current sequence value changes no counter and no cause.
- R7: A displacement clears the line's live bit, so a second displacement of the same line without an intervening load counts nothing.
- R8: A trap strobe raises the named thread's counter by one and sets its cause to 3. If a matching displacement for the same thread occurs in the same cycle, the counter rises by two and the cause is 3.
- R9: A matching displacement changes only the owning thread's counter, even if another thread's sequence value equals the stamp.
- R10: A stale stamp that matches again after the sequence value has wrapped or been rewritten to the same value is counted as interference.
- R11: If a load and a displacement hit the same line in one cycle, the check uses the stamp from before that cycle, and the line then holds the load's stamp and is live.
- R12: With `irq_en` high in the cycle of an event, `irq_pulse[t]` is high for exactly the one cycle in which thread t's new counter value first appears. With `irq_en` low there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load strobe |
| ld_line | input | LINE_W | Line index of the load |
| ld_tid | input | TID_W | Thread issuing the load |
| dsp_valid | input | 1 | Displacement strobe |
| dsp_line | input | LINE_W | Line index leaving the cache |
| dsp_remote | input | 1 | 1 = remote invalidation, 0 = local eviction |
| trap_valid | input | 1 | Taken trap or exception strobe |
| trap_tid | input | TID_W | Thread that took the trap |
| seq_wr_en | input | 1 | Sequence register write strobe |
| seq_wr_tid | input | TID_W | Thread whose sequence register is written |
| seq_wr_data | input | SEQ_W | Value written |
| rd_tid | input | TID_W | Thread whose registers are shown on the read outputs |
| rd_seq | output | SEQ_W | Sequence register of `rd_tid` |
| rd_intf | output | CNT_W | Interference counter of `rd_tid` |
| rd_cause | output | 2 | Last-increment cause of `rd_tid` (0 none, 1 local, 2 remote, 3 trap) |
| irq_en | input | 1 | Interrupt mode enable |
| irq_pulse | output | NUM_THREADS | Per-thread one-cycle interference request |

## Verification
The directed patterns separate matching from mismatching stamps, remote from local causes, and the owning thread from a thread that only happens to hold an equal sequence value. Further directed cases set a load against a same-cycle register write, a load against a same-cycle displacement of the same line, and a trap against a same-cycle matching displacement; each of these shows whether the block uses the old or the new value. A long seeded random run keeps line indices and sequence values in small ranges, so that stamps collide, wrap back and get displaced again. Each cycle is compared with a bench model of the stamp table, the registers, the counters and the pulses.

// File: rtl/rs_track_pkg.sv
package rs_track_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LOCAL  = 2'd1,
    CAUSE_REMOTE = 2'd2,
    CAUSE_TRAP   = 2'd3
  } cause_e;
endpackage

// File: rtl/rs_tag_array.sv
module rs_tag_array #(
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 4,
  parameter int SEQ_W     = 8,
  parameter int TID_W     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [SEQ_W-1:0]  ld_stamp,
  input  logic [TID_W-1:0]  ld_owner,
  input  logic              dsp_en,
  input  logic [LINE_W-1:0] dsp_line,
  output logic              dsp_live,
  output logic [SEQ_W-1:0]  dsp_stamp,
  output logic [TID_W-1:0]  dsp_owner
);
  logic [NUM_LINES-1:0]            live_all;
  logic [NUM_LINES-1:0][SEQ_W-1:0] stamp_all;
  logic [NUM_LINES-1:0][TID_W-1:0] owner_all;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [LINE_W-1:0] IDX = LINE_W'(i);
    logic             live_r;
    logic [SEQ_W-1:0] stamp_r;
    logic [TID_W-1:0] owner_r;
    logic             ld_sel;
    logic             dsp_sel;

    assign ld_sel  = ld_en && (ld_line == IDX);
    assign dsp_sel = dsp_en && (dsp_line == IDX);

    // a load on the same line wins over the displacement clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_r  <= 1'b0;
        stamp_r <= '0;
        owner_r <= '0;
      end else if (ld_sel) begin
        live_r  <= 1'b1;
        stamp_r <= ld_stamp;
        owner_r <= ld_owner;
      end else if (dsp_sel) begin
        live_r  <= 1'b0;
      end
    end

    assign live_all[i]  = live_r;
    assign stamp_all[i] = stamp_r;
    assign owner_all[i] = owner_r;
  end

  // pre-update view of the displaced line
  assign dsp_live  = live_all[dsp_line];
  assign dsp_stamp = stamp_all[dsp_line];
  assign dsp_owner = owner_all[dsp_line];
endmodule

// File: rtl/rs_seq_file.sv
module rs_seq_file #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1,
  parameter int SEQ_W       = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [TID_W-1:0]                  wr_tid,
  input  logic [SEQ_W-1:0]                  wr_data,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0] seq_all
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(t);
    logic [SEQ_W-1:0] seq_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seq_r <= '0;
      else if (wr_en && (wr_tid == TID))  seq_r <= wr_data;
    end

    assign seq_all[t] = seq_r;
  end
endmodule

// File: rtl/rs_intf_unit.sv
module rs_intf_unit
  import rs_track_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_hit,
  input  logic             disp_remote,
  input  logic             trap,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [1:0]       cause_q,
  output logic             irq_q
);
  logic [1:0] step;
  cause_e     cause_nx;

  always_comb begin
    step = {1'b0, disp_hit} + {1'b0, trap};
    if (trap)             cause_nx = CAUSE_TRAP;
    else if (disp_remote) cause_nx = CAUSE_REMOTE;
    else                  cause_nx = CAUSE_LOCAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cause_q <= CAUSE_NONE;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= irq_en && (step != 2'd0);
      if (step != 2'd0) begin
        cnt_q   <= cnt_q + CNT_W'(step);
        cause_q <= cause_nx;
      end
    end
  end
endmodule

// File: rtl/rs_track_top.sv
module rs_track_top #(
  parameter int NUM_LINES   = 16,
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 8,
  parameter int CNT_W       = 64,
  parameter int LINE_W      = $clog2(NUM_LINES),
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [LINE_W-1:0]      ld_line,
  input  logic [TID_W-1:0]       ld_tid,
  input  logic                   dsp_valid,
  input  logic [LINE_W-1:0]      dsp_line,
  input  logic                   dsp_remote,
  input  logic                   trap_valid,
  input  logic [TID_W-1:0]       trap_tid,
  input  logic                   seq_wr_en,
  input  logic [TID_W-1:0]       seq_wr_tid,
  input  logic [SEQ_W-1:0]       seq_wr_data,
  input  logic [TID_W-1:0]       rd_tid,
  output logic [SEQ_W-1:0]       rd_seq,
  output logic [CNT_W-1:0]       rd_intf,
  output logic [1:0]             rd_cause,
  input  logic                   irq_en,
  output logic [NUM_THREADS-1:0] irq_pulse
);
  logic [NUM_THREADS-1:0][SEQ_W-1:0] seq_all;
  logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_THREADS-1:0][1:0]       cause_all;
  logic              dsp_live;
  logic [SEQ_W-1:0]  dsp_stamp;
  logic [TID_W-1:0]  dsp_owner;
  logic [SEQ_W-1:0]  owner_seq;
  logic              dsp_match;

  rs_seq_file #(
    .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .SEQ_W(SEQ_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seq_wr_en), .wr_tid(seq_wr_tid), .wr_data(seq_wr_data),
    .seq_all(seq_all)
  );

  rs_tag_array #(
    .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .SEQ_W(SEQ_W), .TID_W(TID_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_valid), .ld_line(ld_line),
    .ld_stamp(seq_all[ld_tid]), .ld_owner(ld_tid),
    .dsp_en(dsp_valid), .dsp_line(dsp_line),
    .dsp_live(dsp_live), .dsp_stamp(dsp_stamp), .dsp_owner(dsp_owner)
  );

  assign owner_seq = seq_all[dsp_owner];
  assign dsp_match = dsp_valid && dsp_live && (dsp_stamp == owner_seq);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(t);
    logic hit_t;
    logic trap_t;

    assign hit_t  = dsp_match && (dsp_owner == TID);
    assign trap_t = trap_valid && (trap_tid == TID);

    rs_intf_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .disp_hit(hit_t), .disp_remote(dsp_remote),
      .trap(trap_t), .irq_en(irq_en),
      .cnt_q(cnt_all[t]), .cause_q(cause_all[t]), .irq_q(irq_pulse[t])
    );
  end

  assign rd_seq   = seq_all[rd_tid];
  assign rd_intf  = cnt_all[rd_tid];
  assign rd_cause = cause_all[rd_tid];
endmodule

// File: rtl/rs_track_chk.sv
module rs_track_chk #(
  parameter int NUM_THREADS = 2,
  parameter int CNT_W       = 64,
  parameter int TID_W       = 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              dsp_valid,
  input logic                              trap_valid,
  input logic [TID_W-1:0]                  trap_tid,
  input logic                              irq_en,
  input logic [NUM_THREADS-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_THREADS-1:0][1:0]       cause_all,
  input logic [NUM_THREADS-1:0]            irq_pulse
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(t);

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_valid && !trap_valid) |=> $stable(cnt_all[t]));

    // R8
    trap_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_tid == TID) |=> (cnt_all[t] != $past(cnt_all[t])) && (cause_all[t] == 2'd3));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cnt_all[t] - $past(cnt_all[t])) <= CNT_W'(2)));

    // R12
    irq_on_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[t] |-> (cnt_all[t] != $past(cnt_all[t])) && $past(irq_en));

    // R12
    inc_gives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_all[t] != $past(cnt_all[t])) |-> (irq_pulse[t] == $past(irq_en)));
  end
endmodule

bind rs_track_top rs_track_chk #(
  .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dsp_valid(dsp_valid),
  .trap_valid(trap_valid), .trap_tid(trap_tid), .irq_en(irq_en),
  .cnt_all(cnt_all), .cause_all(cause_all), .irq_pulse(irq_pulse)
);

// File: tb/rs_track_top_test.sv
module rs_track_top_test;
  localparam int NT = 2;
  localparam int NL = 16;
  localparam int SW = 8;
  localparam int CW = 64;
  localparam int LW = 4;
  localparam int TW = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ld_valid = 0, dsp_valid = 0, dsp_remote = 0, trap_valid = 0;
  logic          seq_wr_en = 0, irq_en = 0;
  logic [LW-1:0] ld_line = '0, dsp_line = '0;
  logic [TW-1:0] ld_tid = '0, trap_tid = '0, seq_wr_tid = '0, rd_tid = '0;
  logic [SW-1:0] seq_wr_data = '0;
  logic [SW-1:0] rd_seq;
  logic [CW-1:0] rd_intf;
  logic [1:0]    rd_cause;
  logic [NT-1:0] irq_pulse;

  rs_track_top uut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_line(ld_line), .ld_tid(ld_tid),
    .dsp_valid(dsp_valid), .dsp_line(dsp_line), .dsp_remote(dsp_remote),
    .trap_valid(trap_valid), .trap_tid(trap_tid),
    .seq_wr_en(seq_wr_en), .seq_wr_tid(seq_wr_tid), .seq_wr_data(seq_wr_data),
    .rd_tid(rd_tid), .rd_seq(rd_seq), .rd_intf(rd_intf), .rd_cause(rd_cause),
    .irq_en(irq_en), .irq_pulse(irq_pulse)
  );

  // bench model
  logic [SW-1:0] m_seq   [NT];
  logic [CW-1:0] m_cnt   [NT];
  logic [1:0]    m_cause [NT];
  logic          m_irq   [NT];
  logic          m_live  [NL];
  logic [SW-1:0] m_stamp [NL];
  int            m_owner [NL];

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string lbl, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", lbl, got, exp);
    end
  endtask

  function automatic bit model_match(int line);
    return m_live[line] && (m_stamp[line] == m_seq[m_owner[line]]);
  endfunction

  task automatic check_all(string lbl);
    for (int t = 0; t < NT; t++) begin
      rd_tid = TW'(t);
      #1;
      chk({lbl, " seq"},   64'(rd_seq),       64'(m_seq[t]));
      chk({lbl, " intf"},  rd_intf,           m_cnt[t]);
      chk({lbl, " cause"}, 64'(rd_cause),     64'(m_cause[t]));
      chk({lbl, " irq"},   64'(irq_pulse[t]), 64'(m_irq[t]));
    end
  endtask

  task automatic cyc(string lbl, bit lv, int ll, int lt, bit dv, int dl, bit dr,
                     bit tv, int tt, bit wv, int wt, int wd, bit ie);
    bit hit;
    int own;
    ld_valid = lv;  ld_line = LW'(ll);  ld_tid = TW'(lt);
    dsp_valid = dv; dsp_line = LW'(dl); dsp_remote = dr;
    trap_valid = tv; trap_tid = TW'(tt);
    seq_wr_en = wv; seq_wr_tid = TW'(wt); seq_wr_data = SW'(wd);
    irq_en = ie;
    hit = dv && model_match(dl);
    own = m_owner[dl];
    for (int t = 0; t < NT; t++) begin
      int inc;
      inc = ((hit && own == t) ? 1 : 0) + ((tv && tt == t) ? 1 : 0);
      m_irq[t] = ie && (inc > 0);
      if (inc > 0) begin
        m_cnt[t] = m_cnt[t] + CW'(inc);
        m_cause[t] = (tv && tt == t) ? 2'd3 : (dr ? 2'd2 : 2'd1);
      end
    end
    if (dv) m_live[dl] = 1'b0;
    if (lv) begin
      m_live[ll] = 1'b1;
      m_stamp[ll] = m_seq[lt];
      m_owner[ll] = lt;
    end
    if (wv) m_seq[wt] = SW'(wd);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 0; dsp_valid = 0; trap_valid = 0; seq_wr_en = 0;
    check_all(lbl);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int t = 0; t < NT; t++) begin
      m_seq[t] = '0; m_cnt[t] = '0; m_cause[t] = '0; m_irq[t] = 0;
    end
    for (int i = 0; i < NL; i++) begin
      m_live[i] = 0; m_stamp[i] = '0; m_owner[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    // never-loaded line, stamp zero equals seq zero but not live
    cyc("R1 unloaded dsp",      0,0,0, 1,0,1, 0,0, 0,0,0, 0);
    cyc("R2 seq write",         0,0,0, 0,0,0, 0,0, 1,0,5, 0);
    // load uses old seq 5 while seq becomes 7
    cyc("R3 load vs write",     1,2,0, 0,0,0, 0,0, 1,0,7, 0);
    cyc("R2 seq rewrite",       0,0,0, 0,0,0, 0,0, 1,0,5, 0);
    cyc("R4 remote hit",        0,0,0, 1,2,1, 0,0, 0,0,0, 0);
    cyc("R7 second dsp",        0,0,0, 1,2,1, 0,0, 0,0,0, 0);
    cyc("R5 load",              1,3,0, 0,0,0, 0,0, 0,0,0, 0);
    cyc("R5 local hit",         0,0,0, 1,3,0, 0,0, 0,0,0, 0);
    cyc("R6 load",              1,4,0, 0,0,0, 0,0, 1,0,6, 0);
    cyc("R6 mismatch",          0,0,0, 1,4,1, 0,0, 0,0,0, 0);
    cyc("R9 seq t1",            0,0,0, 0,0,0, 0,0, 1,1,6, 0);
    cyc("R9 load t0",           1,5,0, 0,0,0, 0,0, 0,0,0, 0);
    cyc("R9 owner only",        0,0,0, 1,5,1, 0,0, 0,0,0, 0);
    cyc("R9 load t1",           1,6,1, 0,0,0, 0,0, 0,0,0, 0);
    cyc("R9 t1 hit",            0,0,0, 1,6,0, 0,0, 0,0,0, 0);
    cyc("R8 trap t1",           0,0,0, 0,0,0, 1,1, 0,0,0, 0);
    cyc("R8 load t0",           1,9,0, 0,0,0, 0,0, 0,0,0, 0);
    cyc("R8 trap plus hit",     0,0,0, 1,9,1, 1,0, 0,0,0, 0);
    cyc("R11 load",             1,7,0, 0,0,0, 0,0, 1,0,9, 0);
    cyc("R11 same cycle",       1,7,0, 1,7,1, 0,0, 0,0,0, 0);
    cyc("R11 restamped",        0,0,0, 1,7,1, 0,0, 0,0,0, 0);
    cyc("R10 seq 255",          0,0,0, 0,0,0, 0,0, 1,0,255, 0);
    cyc("R10 load",             1,8,0, 0,0,0, 0,0, 1,0,0, 0);
    cyc("R10 wrap back",        0,0,0, 0,0,0, 0,0, 1,0,255, 0);
    cyc("R10 stale match",      0,0,0, 1,8,0, 0,0, 0,0,0, 0);
    cyc("R12 irq on",           0,0,0, 0,0,0, 1,0, 0,0,0, 1);
    cyc("R12 irq drop",         0,0,0, 0,0,0, 0,0, 0,0,0, 1);
    cyc("R12 irq off",          0,0,0, 0,0,0, 1,1, 0,0,0, 0);
    for (int n = 0; n < 3000; n++) begin
      cyc("R3 R4 R5 R6 R7 R9 R11 R12 random",
          ($urandom % 2) == 0, int'($urandom % 8), int'($urandom % NT),
          ($urandom % 3) == 0, int'($urandom % 8), ($urandom % 2) == 0,
          ($urandom % 16) == 0, int'($urandom % NT),
          ($urandom % 8) == 0, int'($urandom % NT), int'($urandom % 4),
          ($urandom % 2) == 0);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule